// File: doc/BRIEF.md
# Dual-Channel Byte-Loaded Converter Code Register Bank

This block is the digital front end of a two-channel 12-bit converter. A narrow parallel bus (eight data lines, two address lines and active-low select, write, update and clear strobes) loads each channel's 12-bit code in two pieces. The low eight bits go into a byte register and the top four bits into a nibble register. One holding register per channel drives the converter core. Because of this double buffering, both channels can be staged in advance and then switched at the same instant.

All strobes are sampled on a system clock. Each falling edge of the sampled write strobe starts exactly one action. With select low and update high, it writes an input register. With update low and select high, it copies both channels' input registers into their holding registers. With select and update both low, it does both at once, so the outputs follow the bus. The clear strobe zeroes every register asynchronously and also serves as the block's reset. The bus has no back-pressure: every qualified write edge is accepted, and a stream-style valid/ready pair is not used. Software loads the low byte first, then the nibble, then issues an update.

Top module: `dual_dac_frontend`

## Requirements
- R1: While clear is low, both output codes and all four input registers read zero. After clear is released, both codes stay 0x000 until the next update.
- R2: An input register changes only on a falling write edge sampled while select is low. A write edge with select high and update high changes nothing. A write strobe held low causes only one action.
- R3: The address selects the target register: 00 is channel A byte, 01 is channel A nibble, 10 is channel B byte and 11 is channel B nibble.
- R4: A byte write stores data bits 7..0 as code bits 7..0. A nibble write stores data bits 3..0 as code bits 11..8, and data bits 7..4 have no effect.
- R5: A write edge with update low and select high loads both holding registers from their input registers in the same clock cycle.
- R6: Rewriting an input register with update high leaves both output codes unchanged.
- R7: A write edge with select and update both low writes the addressed input register and loads both holding registers, including the new value, in the same cycle.
- R8: Clear acts at once, without a clock edge, even in the middle of a write. A write strobe that is still low when clear is released performs no action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| clr_n | input | 1 | Asynchronous clear and reset, active low |
| bus_data | input | 8 | Data lines |
| bus_addr | input | 2 | Register select lines |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low, acts on its sampled falling edge |
| upd_n | input | 1 | Update strobe, active low |
| code_a | output | 12 | Channel A holding register |
| code_b | output | 12 | Channel B holding register |

## Verification
The embedded assertions check the following on every cycle:
- the input registers hold still when no write is decoded;
- the holding registers hold still when no load is decoded;
- at most one input register is enabled at a time;
- a single write edge never produces actions in two consecutive cycles;
- both codes are zero on the first cycle after clear is released.

Only the bench scenarios can show the rest:
- that the address map and nibble masking place the data bits correctly;
- that an update moves both staged channels together;
- that transparent writes carry the fresh value through;
- that a clear pulse in the middle of a write leaves no residual write behind.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;
  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_WRITE  = 2'd1,
    ACT_UPDATE = 2'd2,
    ACT_THRU   = 2'd3
  } bus_act_e;
endpackage

// File: rtl/dac_strobe_sampler.sv
module dac_strobe_sampler
  import dac_fe_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic [DATA_W-1:0] bus_data,
  input  logic [SEL_W-1:0]  bus_addr,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              upd_n,
  output logic [DATA_W-1:0] data_q,
  output logic [SEL_W-1:0]  sel_q,
  output bus_act_e          act
);
  logic cs_q, upd_q, wr_q, wr_prev;
  logic wr_fall;

  // Strobe history resets to "low seen" so a strobe held through clear is not an edge.
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      cs_q    <= 1'b1;
      upd_q   <= 1'b1;
      wr_q    <= 1'b0;
      wr_prev <= 1'b0;
      data_q  <= '0;
      sel_q   <= '0;
    end else begin
      cs_q    <= cs_n;
      upd_q   <= upd_n;
      wr_q    <= wr_n;
      wr_prev <= wr_q;
      data_q  <= bus_data;
      sel_q   <= bus_addr;
    end
  end

  assign wr_fall = wr_prev & ~wr_q;

  always_comb begin
    act = ACT_NONE;
    if (wr_fall) begin
      unique case ({cs_q, upd_q})
        2'b01:   act = ACT_WRITE;
        2'b10:   act = ACT_UPDATE;
        2'b00:   act = ACT_THRU;
        default: act = ACT_NONE;
      endcase
    end
  end

  AST_SINGLE_EDGE: assert property (@(posedge clk) disable iff (!clr_n)
    (act != ACT_NONE) |=> (act == ACT_NONE)); // R2
endmodule

// File: rtl/dac_input_bank.sv
module dac_input_bank #(
  parameter int DATA_W = 8,
  parameter int HI_W   = 4,
  parameter int NUM_CH = 2,
  localparam int CODE_W = DATA_W + HI_W,
  localparam int SEL_W  = $clog2(NUM_CH) + 1
) (
  input  logic                           clk,
  input  logic                           clr_n,
  input  logic                           wr_en,
  input  logic [SEL_W-1:0]               sel,
  input  logic [DATA_W-1:0]              data,
  output logic [NUM_CH-1:0][CODE_W-1:0]  merged
);
  logic [2*NUM_CH-1:0]          en_vec;
  logic [NUM_CH*CODE_W-1:0]     store_flat;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [DATA_W-1:0] lo_q;
    logic [HI_W-1:0]   hi_q;
    logic              sel_ch, lo_en, hi_en;

    // Upper select bits pick the channel, bit 0 picks byte (0) or nibble (1).
    assign sel_ch = ((sel >> 1) == SEL_W'(ch));
    assign lo_en  = wr_en & sel_ch & ~sel[0];
    assign hi_en  = wr_en & sel_ch &  sel[0];

    always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n) begin
        lo_q <= '0;
        hi_q <= '0;
      end else begin
        if (lo_en) lo_q <= data;
        if (hi_en) hi_q <= data[HI_W-1:0];
      end
    end

    // Staged value with this cycle's write folded in, used by pass-through loads.
    assign merged[ch] = {hi_en ? data[HI_W-1:0] : hi_q, lo_en ? data : lo_q};
    assign en_vec[2*ch]     = lo_en;
    assign en_vec[2*ch+1]   = hi_en;
    assign store_flat[ch*CODE_W +: CODE_W] = {hi_q, lo_q};
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!clr_n)
    $onehot0(en_vec)); // R3

  AST_INPUT_HOLD: assert property (@(posedge clk) disable iff (!clr_n)
    !wr_en |=> $stable(store_flat)); // R2
endmodule

// File: rtl/dac_hold_bank.sv
module dac_hold_bank #(
  parameter int CODE_W = 12,
  parameter int NUM_CH = 2
) (
  input  logic                          clk,
  input  logic                          clr_n,
  input  logic                          load,
  input  logic [NUM_CH-1:0][CODE_W-1:0] src,
  output logic [NUM_CH-1:0][CODE_W-1:0] hold
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_hold
    always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n)    hold[ch] <= '0;
      else if (load) hold[ch] <= src[ch];
    end
  end

  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!clr_n)
    !load |=> $stable(hold)); // R6
endmodule

// File: rtl/dual_dac_frontend.sv
module dual_dac_frontend
  import dac_fe_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int HI_W   = 4,
  localparam int CODE_W = DATA_W + HI_W,
  localparam int NUM_CH = 2,
  localparam int SEL_W  = $clog2(NUM_CH) + 1
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic [DATA_W-1:0] bus_data,
  input  logic [SEL_W-1:0]  bus_addr,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              upd_n,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b
);
  logic [DATA_W-1:0]               data_q;
  logic [SEL_W-1:0]                sel_q;
  bus_act_e                        act;
  logic                            wr_en, load;
  logic [NUM_CH-1:0][CODE_W-1:0]   merged;
  logic [NUM_CH-1:0][CODE_W-1:0]   hold;

  dac_strobe_sampler #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_sample (
    .clk(clk), .clr_n(clr_n), .bus_data(bus_data), .bus_addr(bus_addr),
    .cs_n(cs_n), .wr_n(wr_n), .upd_n(upd_n),
    .data_q(data_q), .sel_q(sel_q), .act(act)
  );

  assign wr_en = (act == ACT_WRITE)  || (act == ACT_THRU);
  assign load  = (act == ACT_UPDATE) || (act == ACT_THRU);

  dac_input_bank #(.DATA_W(DATA_W), .HI_W(HI_W), .NUM_CH(NUM_CH)) u_inputs (
    .clk(clk), .clr_n(clr_n), .wr_en(wr_en), .sel(sel_q), .data(data_q),
    .merged(merged)
  );

  dac_hold_bank #(.CODE_W(CODE_W), .NUM_CH(NUM_CH)) u_hold (
    .clk(clk), .clr_n(clr_n), .load(load), .src(merged), .hold(hold)
  );

  assign code_a = hold[0];
  assign code_b = hold[1];

  AST_ZERO_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!clr_n)
    $rose(clr_n) |-> (code_a == '0 && code_b == '0)); // R1
endmodule

// File: tb/dual_dac_frontend_tb_top.sv
module dual_dac_frontend_tb_top;
  logic       clk = 1'b0;
  logic       clr_n = 1'b0;
  logic [7:0] bus_data = '0;
  logic [1:0] bus_addr = '0;
  logic       cs_n = 1'b1, wr_n = 1'b1, upd_n = 1'b1;
  logic [11:0] code_a, code_b;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [11:0] a;
    logic [11:0] b;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  // Reference model state
  logic [7:0] m_lo [2];
  logic [3:0] m_hi [2];
  logic [11:0] m_hold [2];

  always #10 clk = ~clk;

  dual_dac_frontend dut_i (
    .clk(clk), .clr_n(clr_n), .bus_data(bus_data), .bus_addr(bus_addr),
    .cs_n(cs_n), .wr_n(wr_n), .upd_n(upd_n), .code_a(code_a), .code_b(code_b)
  );

  task automatic compare(input logic [11:0] ea, input logic [11:0] eb, input string tag);
    checks++;
    if (code_a !== ea || code_b !== eb) begin
      errors++;
      $display("FAIL %s: code_a=%h code_b=%h expected %h %h", tag, code_a, code_b, ea, eb);
    end
  endtask

  // Monitor: pops expectations and compares against outputs away from the edge.
  always @(negedge clk) begin
    if (exp_q.size() != 0) begin
      exp_t e;
      e = exp_q.pop_front();
      compare(e.a, e.b, e.tag);
    end
  end

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      m_lo[c] = '0; m_hi[c] = '0; m_hold[c] = '0;
    end
  endtask

  // Driver: one bus cycle, model update, expectation pushed.
  task automatic bus_op(input logic cs, input logic upd, input logic [1:0] adr,
                        input logic [7:0] d, input string tag);
    exp_t e;
    @(negedge clk);
    bus_addr = adr; bus_data = d; cs_n = cs; upd_n = upd; wr_n = 1'b0;
    repeat (3) @(negedge clk);
    wr_n = 1'b1; cs_n = 1'b1; upd_n = 1'b1;
    repeat (2) @(negedge clk);
    if (!cs) begin
      if (adr[0]) m_hi[adr[1]] = d[3:0];
      else        m_lo[adr[1]] = d;
    end
    if (!upd) begin
      for (int c = 0; c < 2; c++) m_hold[c] = {m_hi[c], m_lo[c]};
    end
    e.a = m_hold[0]; e.b = m_hold[1]; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    compare(12'h000, 12'h000, "R1 codes zero during clear");
    clr_n = 1'b1;
    repeat (2) @(negedge clk);
    compare(12'h000, 12'h000, "R1 codes zero after clear release");

    // Stage both channels without update (R3, R4, R6)
    bus_op(1'b0, 1'b1, 2'b00, 8'h34, "R3 A byte staged, outputs hold");
    bus_op(1'b0, 1'b1, 2'b01, 8'hF2, "R4 A nibble staged, upper data ignored");
    bus_op(1'b0, 1'b1, 2'b10, 8'hCD, "R3 B byte staged");
    bus_op(1'b0, 1'b1, 2'b11, 8'h0A, "R6 B nibble staged, outputs hold");
    // Simultaneous update (R5): expect A=234, B=ACD
    bus_op(1'b1, 1'b0, 2'b00, 8'h00, "R5 simultaneous update");
    // Rewrite without update (R6)
    bus_op(1'b0, 1'b1, 2'b00, 8'h00, "R6 rewrite leaves codes");
    // Select high: ignored (R2)
    bus_op(1'b1, 1'b1, 2'b01, 8'h07, "R2 write with select high ignored");
    bus_op(1'b1, 1'b0, 2'b00, 8'h00, "R2 update shows nibble untouched");
    // Transparent writes (R7)
    bus_op(1'b0, 1'b0, 2'b10, 8'h11, "R7 pass-through B byte");
    bus_op(1'b0, 1'b0, 2'b11, 8'h35, "R7 pass-through B nibble");
    bus_op(1'b0, 1'b0, 2'b01, 8'hE9, "R7 pass-through A nibble");
    // Long strobe: only one action (R2)
    bus_op(1'b0, 1'b1, 2'b00, 8'h5A, "R2 held strobe single write");

    // Clear in the middle of a write (R8)
    repeat (4) @(negedge clk);
    bus_addr = 2'b00; bus_data = 8'hFF; cs_n = 1'b0; upd_n = 1'b0; wr_n = 1'b0;
    #5 clr_n = 1'b0;
    #1 compare(12'h000, 12'h000, "R8 clear acts without clock");
    model_reset();
    @(negedge clk);
    clr_n = 1'b1;
    repeat (5) @(negedge clk);
    compare(12'h000, 12'h000, "R8 strobe held through clear performs no write");
    wr_n = 1'b1; cs_n = 1'b1; upd_n = 1'b1;
    repeat (3) @(negedge clk);
    bus_op(1'b1, 1'b0, 2'b00, 8'h00, "R1 inputs zero after clear");

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule